// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects an A port and a B port through a set of independently controlled byte lanes. By default there are two lanes of eight bits each. Tying their controls together makes a single 16-bit transceiver. Each lane has two capture registers. The forward register samples the A bus and the reverse register samples the B bus. Each register loads on the low-to-high transition of its own capture strobe. An active-low output enable and a direction input decide which single port the lane drives. Two select inputs decide whether the driven port carries live data from the opposite bus or the stored register value.

Each bidirectional pin is split into an input, an output value and an output enable, so the block suits synthesis. The strobes are sampled on the system clock, and a rise is detected by comparing each strobe with its value on the previous cycle. All port values and enables leave the block from flops. Switching a select therefore moves the output straight from one source to the other at a clock edge, with no intermediate value. With the output enable high the lane is isolated: neither port is driven, yet both registers keep capturing.

Top module: `tfr_bus_transceiver`

## Requirements
- R1: While `rst` is high at a clock edge, every capture register, strobe history flop, port output value and port enable is cleared to zero on that edge.
- R2: The forward register of a lane loads that lane's `a_in` slice on the first edge at which `cap_ab` is sampled high after being sampled low. While `cap_ab` stays high, later edges do not reload the register.
- R3: The reverse register of a lane loads that lane's `b_in` slice on the first edge at which `cap_ba` is sampled high after being sampled low. A held-high level does not reload it.
- R4: When `out_en_n` is 0 at an edge, the lane drives exactly one port from that edge on. With `dir_a2b` = 1 it drives B (`b_oe` = 1, `a_oe` = 0). With `dir_a2b` = 0 it drives A (`a_oe` = 1, `b_oe` = 0).
- R5: When `out_en_n` is 1 at an edge, both `a_oe` and `b_oe` of that lane are 0 after that edge. Strobe rises during this isolation still load both registers.
- R6: `a_oe` and `b_oe` of a lane are never 1 at the same time.
- R7: The B-side output slice takes, at each edge, the forward register's value before that edge when `sel_ab` = 1. It takes the live `a_in` slice when `sel_ab` = 0.
- R8: The A-side output slice takes, at each edge, the reverse register's value before that edge when `sel_ba` = 1. It takes the live `b_in` slice when `sel_ba` = 0.
- R9: Each lane's controls affect only its own slices and enable bits. Lane g occupies data bits [g*8 +: 8] and enable bit g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en_n | input | NUM_LANES | Per-lane active-low output enable; 1 isolates the lane |
| dir_a2b | input | NUM_LANES | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab | input | NUM_LANES | Per-lane source for B output: 1 stored, 0 live |
| sel_ba | input | NUM_LANES | Per-lane source for A output: 1 stored, 0 live |
| cap_ab | input | NUM_LANES | Per-lane forward register capture strobe (rise loads) |
| cap_ba | input | NUM_LANES | Per-lane reverse register capture strobe (rise loads) |
| a_in | input | LANE_W*NUM_LANES | Value seen on the A pins |
| b_in | input | LANE_W*NUM_LANES | Value seen on the B pins |
| a_out | output | LANE_W*NUM_LANES | Value driven onto the A pins when enabled |
| a_oe | output | NUM_LANES | Per-lane A pin drive enable |
| b_out | output | LANE_W*NUM_LANES | Value driven onto the B pins when enabled |
| b_oe | output | NUM_LANES | Per-lane B pin drive enable |

## Verification
The first directed pattern loads a byte through a strobe rise and then changes the A data while the strobe is held high. Only a register that loads on the edge alone keeps the first byte. A second pattern captures B data while the lane is isolated and only then turns the drive toward A, which shows that capture does not depend on the output state. Toggling the selects on one lane while the other lane stays isolated tells stored data from live data and exposes any crosstalk between lanes. A long stretch of seeded random controls, strobes, data and occasional resets then covers every combination of enable, direction and select. It is compared each cycle with a model computed in the bench.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_TO_B = 2'b01,
        DRV_TO_A = 2'b10
    } drive_e;

    typedef struct packed {
        logic out_en_n;
        logic dir_a2b;
        logic sel_ab;
        logic sel_ba;
        logic cap_ab;
        logic cap_ba;
    } lane_ctl_t;

    function automatic drive_e decode_drive(input logic out_en_n, input logic dir_a2b);
        if (out_en_n)
            return DRV_OFF;
        else if (dir_a2b)
            return DRV_TO_B;
        else
            return DRV_TO_A;
    endfunction

    function automatic logic rise_seen(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/tfr_edge_capture.sv
module tfr_edge_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import tfr_pkg::*;

    logic strobe_prev;
    logic load;

    assign load = rise_seen(strobe, strobe_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev <= 1'b0;
            q           <= '0;
        end else begin
            strobe_prev <= strobe;
            if (load)
                q <= d;
        end
    end
endmodule

// File: rtl/tfr_path_out.sv
module tfr_path_out #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         use_stored,
    input  logic [W-1:0] stored,
    input  logic [W-1:0] live,
    output logic [W-1:0] q
);
    logic [W-1:0] chosen;

    assign chosen = use_stored ? stored : live;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= chosen;
    end
endmodule

// File: rtl/tfr_dir_ctrl.sv
module tfr_dir_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic out_en_n,
    input  logic dir_a2b,
    output logic a_oe,
    output logic b_oe
);
    import tfr_pkg::*;

    drive_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= DRV_OFF;
        else
            mode_q <= decode_drive(out_en_n, dir_a2b);
    end

    assign a_oe = (mode_q == DRV_TO_A);
    assign b_oe = (mode_q == DRV_TO_B);
endmodule

// File: rtl/tfr_lane.sv
module tfr_lane #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  tfr_pkg::lane_ctl_t  ctl,
    input  logic [W-1:0]        a_in,
    input  logic [W-1:0]        b_in,
    output logic [W-1:0]        a_out,
    output logic                a_oe,
    output logic [W-1:0]        b_out,
    output logic                b_oe
);
    logic [W-1:0] fwd_reg;
    logic [W-1:0] rev_reg;

    tfr_edge_capture #(.W(W)) u_fwd_cap (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctl.cap_ab),
        .d      (a_in),
        .q      (fwd_reg)
    );

    tfr_edge_capture #(.W(W)) u_rev_cap (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctl.cap_ba),
        .d      (b_in),
        .q      (rev_reg)
    );

    tfr_path_out #(.W(W)) u_to_b (
        .clk        (clk),
        .rst        (rst),
        .use_stored (ctl.sel_ab),
        .stored     (fwd_reg),
        .live       (a_in),
        .q          (b_out)
    );

    tfr_path_out #(.W(W)) u_to_a (
        .clk        (clk),
        .rst        (rst),
        .use_stored (ctl.sel_ba),
        .stored     (rev_reg),
        .live       (b_in),
        .q          (a_out)
    );

    tfr_dir_ctrl u_dir (
        .clk      (clk),
        .rst      (rst),
        .out_en_n (ctl.out_en_n),
        .dir_a2b  (ctl.dir_a2b),
        .a_oe     (a_oe),
        .b_oe     (b_oe)
    );
endmodule

// File: rtl/tfr_bus_transceiver.sv
module tfr_bus_transceiver #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_LANES-1:0]          out_en_n,
    input  logic [NUM_LANES-1:0]          dir_a2b,
    input  logic [NUM_LANES-1:0]          sel_ab,
    input  logic [NUM_LANES-1:0]          sel_ba,
    input  logic [NUM_LANES-1:0]          cap_ab,
    input  logic [NUM_LANES-1:0]          cap_ba,
    input  logic [LANE_W*NUM_LANES-1:0]   a_in,
    input  logic [LANE_W*NUM_LANES-1:0]   b_in,
    output logic [LANE_W*NUM_LANES-1:0]   a_out,
    output logic [NUM_LANES-1:0]          a_oe,
    output logic [LANE_W*NUM_LANES-1:0]   b_out,
    output logic [NUM_LANES-1:0]          b_oe
);
    import tfr_pkg::*;

    localparam int BUS_W = LANE_W * NUM_LANES;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lane_ctl_t ctl;

        assign ctl.out_en_n = out_en_n[g];
        assign ctl.dir_a2b  = dir_a2b[g];
        assign ctl.sel_ab   = sel_ab[g];
        assign ctl.sel_ba   = sel_ba[g];
        assign ctl.cap_ab   = cap_ab[g];
        assign ctl.cap_ba   = cap_ba[g];

        tfr_lane #(.W(LANE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .a_in  (a_in[g*LANE_W +: LANE_W]),
            .b_in  (b_in[g*LANE_W +: LANE_W]),
            .a_out (a_out[g*LANE_W +: LANE_W]),
            .a_oe  (a_oe[g]),
            .b_out (b_out[g*LANE_W +: LANE_W]),
            .b_oe  (b_oe[g])
        );
    end

    if (BUS_W < 1) begin : g_bad_width
        initial $error("bus width must be positive");
    end
endmodule

// File: rtl/tfr_bus_transceiver_chk.sv
module tfr_bus_transceiver_chk #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_LANES-1:0]        out_en_n,
    input logic [NUM_LANES-1:0]        dir_a2b,
    input logic [NUM_LANES-1:0]        sel_ab,
    input logic [NUM_LANES-1:0]        sel_ba,
    input logic [LANE_W*NUM_LANES-1:0] a_in,
    input logic [LANE_W*NUM_LANES-1:0] b_in,
    input logic [LANE_W*NUM_LANES-1:0] a_out,
    input logic [NUM_LANES-1:0]        a_oe,
    input logic [LANE_W*NUM_LANES-1:0] b_out,
    input logic [NUM_LANES-1:0]        b_oe
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
        assert_one_side_R6: assert property (@(posedge clk) disable iff (rst)
            !(a_oe[g] && b_oe[g]));

        assert_isolated_R5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(out_en_n[g])) |-> (!a_oe[g] && !b_oe[g]));

        assert_drive_b_R4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(out_en_n[g]) && $past(dir_a2b[g])) |-> (b_oe[g] && !a_oe[g]));

        assert_drive_a_R4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(out_en_n[g]) && !$past(dir_a2b[g])) |-> (a_oe[g] && !b_oe[g]));

        assert_live_b_R7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(sel_ab[g])) |->
                (b_out[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W])));

        assert_live_a_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(sel_ba[g])) |->
                (a_out[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W])));

        assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (!a_oe[g] && !b_oe[g] &&
                            a_out[g*LANE_W +: LANE_W] == '0 &&
                            b_out[g*LANE_W +: LANE_W] == '0));
    end
endmodule

bind tfr_bus_transceiver tfr_bus_transceiver_chk #(
    .LANE_W    (LANE_W),
    .NUM_LANES (NUM_LANES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .out_en_n (out_en_n),
    .dir_a2b  (dir_a2b),
    .sel_ab   (sel_ab),
    .sel_ba   (sel_ba),
    .a_in     (a_in),
    .b_in     (b_in),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_out    (b_out),
    .b_oe     (b_oe)
);

// File: tb/tfr_bus_transceiver_test.sv
module tfr_bus_transceiver_test;
    localparam int W = 8;
    localparam int L = 2;
    localparam int BW = W * L;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [L-1:0]  out_en_n = '1;
    logic [L-1:0]  dir_a2b = '0;
    logic [L-1:0]  sel_ab = '0;
    logic [L-1:0]  sel_ba = '0;
    logic [L-1:0]  cap_ab = '0;
    logic [L-1:0]  cap_ba = '0;
    logic [BW-1:0] a_in = '0;
    logic [BW-1:0] b_in = '0;
    logic [BW-1:0] a_out;
    logic [L-1:0]  a_oe;
    logic [BW-1:0] b_out;
    logic [L-1:0]  b_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tfr_bus_transceiver #(.LANE_W(W), .NUM_LANES(L)) uut (
        .clk(clk), .rst(rst), .out_en_n(out_en_n), .dir_a2b(dir_a2b),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe)
    );

    // Reference model built from the requirements
    logic [W-1:0] m_fwd [L];
    logic [W-1:0] m_rev [L];
    logic         m_pab [L];
    logic         m_pba [L];
    logic [BW-1:0] m_aout, m_bout;
    logic [L-1:0]  m_aoe, m_boe;

    function automatic logic [W-1:0] pick(logic s, logic [W-1:0] st, logic [W-1:0] lv);
        return s ? st : lv;
    endfunction

    always @(posedge clk) begin
        for (int g = 0; g < L; g++) begin
            if (rst) begin
                m_fwd[g] = '0; m_rev[g] = '0; m_pab[g] = 0; m_pba[g] = 0;
                m_bout[g*W +: W] = '0; m_aout[g*W +: W] = '0;
                m_boe[g] = 0; m_aoe[g] = 0;
            end else begin
                m_bout[g*W +: W] = pick(sel_ab[g], m_fwd[g], a_in[g*W +: W]);
                m_aout[g*W +: W] = pick(sel_ba[g], m_rev[g], b_in[g*W +: W]);
                m_boe[g] = !out_en_n[g] && dir_a2b[g];
                m_aoe[g] = !out_en_n[g] && !dir_a2b[g];
                if (cap_ab[g] && !m_pab[g]) m_fwd[g] = a_in[g*W +: W];
                if (cap_ba[g] && !m_pba[g]) m_rev[g] = b_in[g*W +: W];
                m_pab[g] = cap_ab[g];
                m_pba[g] = cap_ba[g];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_0A1B));
        @(negedge clk);
        // R1: reset clears everything; stored selects expose register zero
        sel_ab = '1; sel_ba = '1; out_en_n = 2'b10; dir_a2b = 2'b01;
        step(); step();
        chk("R1 b_oe in reset", {30'd0, b_oe}, 32'd0);
        chk("R1 b_out in reset", {16'd0, b_out}, 32'd0);
        rst = 0;
        step();
        chk("R1 fwd reg zero after reset", {16'd0, b_out}, 32'd0);
        chk("R4 lane0 drives B", {30'd0, b_oe, a_oe}, {28'd0, 2'b01, 2'b00});
        // R2: capture on strobe rise, held level does not reload
        a_in[7:0] = 8'h5A; cap_ab[0] = 1;
        step(); step();
        chk("R2 captured A byte", {24'd0, b_out[7:0]}, 32'h5A);
        a_in[7:0] = 8'h33;
        step(); step();
        chk("R2 held strobe no reload", {24'd0, b_out[7:0]}, 32'h5A);
        sel_ab[0] = 0;
        step();
        chk("R7 live A data", {24'd0, b_out[7:0]}, 32'h33);
        sel_ab[0] = 1;
        step();
        chk("R7 back to stored", {24'd0, b_out[7:0]}, 32'h5A);
        // R5: isolation still captures
        out_en_n[0] = 1;
        step();
        chk("R5 isolated enables", {30'd0, a_oe[0], b_oe[0]}, 32'd0);
        b_in[7:0] = 8'hC3; cap_ba[0] = 1;
        step();
        chk("R5 still isolated", {30'd0, a_oe[0], b_oe[0]}, 32'd0);
        out_en_n[0] = 0; dir_a2b[0] = 0;
        step();
        chk("R3 byte captured in isolation", {24'd0, a_out[7:0]}, 32'hC3);
        chk("R4 lane0 drives A", {30'd0, a_oe[0], b_oe[0]}, 32'h2);
        b_in[7:0] = 8'h77; sel_ba[0] = 0;
        step();
        chk("R8 live B data", {24'd0, a_out[7:0]}, 32'h77);
        // R9: lane 1 untouched by lane 0 activity
        chk("R9 lane1 enables off", {30'd0, a_oe[1], b_oe[1]}, 32'd0);
        chk("R9 lane1 stored zero", {24'd0, b_out[15:8]}, 32'd0);
        chk("R9 lane1 A stored zero", {24'd0, a_out[15:8]}, 32'd0);

        // Seeded random phase compared against the model
        for (int i = 0; i < 3000; i++) begin
            r = $urandom; a_in = r[15:0]; b_in = r[31:16];
            r = $urandom;
            out_en_n = r[1:0]; dir_a2b = r[3:2]; sel_ab = r[5:4]; sel_ba = r[7:6];
            cap_ab = r[9:8]; cap_ba = r[11:10];
            rst = (r[17:12] == 6'd0);
            step();
            chk("R7 b_out vs model", {16'd0, b_out}, {16'd0, m_bout});
            chk("R8 a_out vs model", {16'd0, a_out}, {16'd0, m_aout});
            chk("R4 R5 enables vs model", {28'd0, a_oe, b_oe}, {28'd0, m_aoe, m_boe});
            chk("R6 never both driven", {30'd0, a_oe & b_oe}, 32'd0);
        end
        done = 1;
        finish_run();
    end
endmodule